// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator machine. It holds a 16-bit accumulator and a 16-bit flag word. On every clock edge where the execute strobe is high, a 4-bit operation code picks one of twelve operations. The accumulator is always one operand, and the operand bus supplies the other where the operation needs one. The result goes back into the accumulator, and the sign, zero and carry flags follow it.

The flag word also carries an event flag. A one-cycle tick from an outside periodic timer sets it, and software clears it through a dedicated strobe after it has polled the flag. This takes the place of a hardware interrupt. The event flag runs independently of the execute strobe, and no arithmetic or logic operation touches it.

There is no load operation. Software brings a value into the accumulator by clearing it with AND 0 and then ORing the value in.

Top module: `acc_alu_unit`

## Requirements
- R1: Accumulator and flag word are 16 bits wide. In the flag word, sign is bit 15, zero is bit 6, event is bit 1 and carry is bit 0. Every other flag bit reads as 0.
- R2: After a flag-updating operation (codes 0 to 11), the sign flag equals bit 15 of the result.
- R3: After a flag-updating operation, the zero flag is 1 exactly when the 16-bit result is all zeros.
- R4: Code 0 (ADD) stores A+B, and code 1 (ADC) stores A+B+carry. Carry takes the carry out of bit 15.
- R5: Code 2 (SUB) stores A-B, and code 3 (SBC) stores A-B-carry. Carry is set when the unsigned subtraction borrows.
- R6: Code 4 (AND), code 5 (OR) and code 6 (XOR) store the bitwise result of A and B. Code 10 (CPL) stores ~A. All four clear carry.
- R7: Code 7 (INC) stores A+1 and code 8 (DEC) stores A-1. Both leave carry unchanged.
- R8: Code 9 (CP) computes A-B and updates sign, zero and carry (carry is the borrow) as SUB does, but leaves the accumulator unchanged.
- R9: Code 11 (NEG) stores 0-A. Carry is set unless A was zero.
- R10: Codes 12 to 15 change neither the accumulator nor the flags. With the execute strobe low, no operation takes effect.
- R11: A tick sets the event flag and the clear strobe clears it. When both arrive in the same cycle, the flag is set. No operation code changes the event flag.
- R12: A synchronous active-low reset sets the accumulator and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe; the operation takes effect on this edge |
| op_i | input | 4 | Operation code |
| operand_i | input | 16 | Second operand (B) |
| tick_i | input | 1 | One-cycle pulse from the periodic timer; sets the event flag |
| eclr_i | input | 1 | Clears the event flag |
| acc_o | output | 16 | Accumulator |
| flags_o | output | 16 | Flag word |

## Verification
The bench builds the unit with its default width of 16 bits. At this width the 0x7FFF/0x8000 and 0xFFFF/0x0000 wrap points lie on the sign bit and the carry bit, where the flags can be checked exactly. Chains of ADC and SBC with the carry already set, a CP that produces a borrow, and NEG on 0 and on 0x8000 reach the carry-in and borrow corner cases. A tick and a clear in the same cycle test the priority of the event flag.

// File: rtl/acc_alu_pkg.sv
// Package: operation codes and flag bit positions shared by the ALU unit.
// Assumes the data width is at least 8 bits so that every flag position exists.
package acc_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_CP  = 4'd9,
        OP_CPL = 4'd10,
        OP_NEG = 4'd11
    } alu_op_e;

    localparam logic [3:0] OP_LAST = 4'd11;  // highest code that does anything
    localparam int FLG_C = 0;
    localparam int FLG_E = 1;
    localparam int FLG_Z = 6;
endpackage

// File: rtl/acc_alu_core.sv
// Combinational datapath. From the op code, accumulator, operand and carry-in it
// computes the result, the carry/borrow out and which state to write.
// Assumes op codes above OP_LAST are no-ops.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              wr_acc,
    output logic              wr_flags,
    output logic              wr_carry
);
    localparam logic [DATA_W:0] ONE_W  = (DATA_W+1)'(1);
    localparam logic [DATA_W:0] ZERO_W = '0;

    logic [DATA_W:0] wide;
    logic [DATA_W:0] a_w;
    logic [DATA_W:0] b_w;
    logic [DATA_W:0] c_w;

    assign a_w = {1'b0, a};
    assign b_w = {1'b0, b};
    assign c_w = {{DATA_W{1'b0}}, cin};

    // Result with one extra bit; the top bit is carry on add, borrow on subtract.
    always_comb begin
        case (op)
            OP_ADD:        wide = a_w + b_w;
            OP_ADC:        wide = a_w + b_w + c_w;
            OP_SUB, OP_CP: wide = a_w - b_w;
            OP_SBC:        wide = a_w - b_w - c_w;
            OP_AND:        wide = {1'b0, a & b};
            OP_OR:         wide = {1'b0, a | b};
            OP_XOR:        wide = {1'b0, a ^ b};
            OP_INC:        wide = a_w + ONE_W;
            OP_DEC:        wide = a_w - ONE_W;
            OP_CPL:        wide = {1'b0, ~a};
            OP_NEG:        wide = ZERO_W - a_w;
            default:       wide = a_w;
        endcase
    end

    assign res  = wide[DATA_W-1:0];
    assign cout = wide[DATA_W];

    // Write enables: CP touches only the flags; INC/DEC keep carry.
    always_comb begin
        wr_flags = (op <= OP_LAST);
        wr_acc   = wr_flags && (op != OP_CP);
        wr_carry = wr_flags && (op != OP_INC) && (op != OP_DEC);
    end
endmodule

// File: rtl/acc_flag_reg.sv
// Flag word register: sign, zero, carry and the event flag. Unused bits are zero.
// Assumes the event tick and clear strobes are synchronous to clk.
module acc_flag_reg
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_sz,
    input  logic              upd_c,
    input  logic              s_in,
    input  logic              z_in,
    input  logic              c_in,
    input  logic              tick,
    input  logic              eclr,
    output logic [DATA_W-1:0] flags
);
    localparam int SIGN_POS = DATA_W - 1;

    logic s_q, z_q, c_q, e_q;

    // Sign and zero follow every flag-updating operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= 1'b0;
            z_q <= 1'b0;
        end else if (upd_sz) begin
            s_q <= s_in;
            z_q <= z_in;
        end
    end

    // Carry updates only when the operation owns it.
    always_ff @(posedge clk) begin
        if (!rst_n)     c_q <= 1'b0;
        else if (upd_c) c_q <= c_in;
    end

    // Event flag: the tick takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    e_q <= 1'b0;
        else if (tick) e_q <= 1'b1;
        else if (eclr) e_q <= 1'b0;
    end

    // Place each flag at its bit position; all other bits stay zero.
    always_comb begin
        flags           = '0;
        flags[SIGN_POS] = s_q;
        flags[FLG_Z]    = z_q;
        flags[FLG_E]    = e_q;
        flags[FLG_C]    = c_q;
    end
endmodule

// File: rtl/acc_alu_unit.sv
// Top: accumulator register, ALU datapath and flag register.
// Assumes a single clock and the synchronous active-low reset.
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              tick_i,
    input  logic              eclr_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] flags_o
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] res;
    logic              cout, wr_acc, wr_flags, wr_carry;

    acc_alu_core #(.DATA_W(DATA_W)) u_core (
        .op       (op_i),
        .a        (acc_q),
        .b        (operand_i),
        .cin      (flags_o[FLG_C]),
        .res      (res),
        .cout     (cout),
        .wr_acc   (wr_acc),
        .wr_flags (wr_flags),
        .wr_carry (wr_carry)
    );

    acc_flag_reg #(.DATA_W(DATA_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_sz (exec_i && wr_flags),
        .upd_c  (exec_i && wr_carry),
        .s_in   (res[DATA_W-1]),
        .z_in   (res == '0),
        .c_in   (cout),
        .tick   (tick_i),
        .eclr   (eclr_i),
        .flags  (flags_o)
    );

    // Accumulator write-back on an executed operation that produces a result.
    always_ff @(posedge clk) begin
        if (!rst_n)                  acc_q <= '0;
        else if (exec_i && wr_acc)   acc_q <= res;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/acc_alu_chk.sv
// Checker for acc_alu_unit, bound to every instance. It observes only the ports.
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              tick_i,
    input logic              eclr_i,
    input logic [DATA_W-1:0] acc_o,
    input logic [DATA_W-1:0] flags_o
);
    localparam int SB = DATA_W - 1;
    localparam logic [DATA_W-1:0] USED_M =
        (DATA_W'(1) << SB) | (DATA_W'(1) << FLG_Z) | (DATA_W'(1) << FLG_E) | DATA_W'(1);

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (acc_o == '0 && flags_o == '0)); // R12
    AST_UNUSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (flags_o & ~USED_M) == '0); // R1
    AST_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op_i <= OP_LAST && op_i != OP_CP |=> flags_o[SB] == acc_o[SB]); // R2
    AST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op_i <= OP_LAST && op_i != OP_CP |=> flags_o[FLG_Z] == (acc_o == '0)); // R3
    AST_LOGIC_CLR_C: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && (op_i inside {OP_AND, OP_OR, OP_XOR, OP_CPL}) |=> !flags_o[FLG_C]); // R6
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && (op_i == OP_INC || op_i == OP_DEC) |=> $stable(flags_o[FLG_C])); // R7
    AST_CP_KEEP_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op_i == OP_CP |=> $stable(acc_o)); // R8
    AST_CP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && op_i == OP_CP |=> flags_o[FLG_Z] == ($past(acc_o) == $past(operand_i))); // R8
    AST_NOP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_i || op_i > OP_LAST) |=> $stable(acc_o) && $stable(flags_o[SB]) &&
        $stable(flags_o[FLG_Z]) && $stable(flags_o[FLG_C])); // R10
    AST_E_SET: assert property (@(posedge clk) disable iff (!rst_n) tick_i |=> flags_o[FLG_E]); // R11
    AST_E_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        eclr_i && !tick_i |=> !flags_o[FLG_E]); // R11
    AST_E_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eclr_i && !tick_i |=> $stable(flags_o[FLG_E])); // R11
endmodule

bind acc_alu_unit acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .op_i      (op_i),
    .operand_i (operand_i),
    .tick_i    (tick_i),
    .eclr_i    (eclr_i),
    .acc_o     (acc_o),
    .flags_o   (flags_o)
);

// File: tb/acc_alu_unit_tb.sv
// Directed bench for acc_alu_unit. Inputs change on falling edges and outputs are
// sampled on the falling edge after the rising edge that acts on them.
module acc_alu_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [15:0] operand_i = 16'd0;
    logic        tick_i = 1'b0;
    logic        eclr_i = 1'b0;
    logic [15:0] acc_o;
    logic [15:0] flags_o;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    acc_alu_unit #(.DATA_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .operand_i(operand_i),
        .tick_i(tick_i), .eclr_i(eclr_i), .acc_o(acc_o), .flags_o(flags_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL R12 watchdog cycles=%0d expected below 20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Flag word per R1: S bit 15, Z bit 6, E bit 1, C bit 0.
    function automatic logic [15:0] fl(input logic s, input logic z, input logic c, input logic e);
        return {s, 8'b0, z, 4'b0, e, c};
    endfunction

    task automatic check(input string tag, input logic [15:0] ea, input logic [15:0] ef);
        checks++;
        if (acc_o !== ea || flags_o !== ef) begin
            failures++;
            $display("FAIL %s acc=%h flags=%h expected acc=%h flags=%h", tag, acc_o, flags_o, ea, ef);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic run_op(input logic [3:0] op, input logic [15:0] b);
        @(negedge clk); exec_i = 1'b1; op_i = op; operand_i = b;
        @(negedge clk); exec_i = 1'b0;
    endtask

    task automatic set_acc(input logic [15:0] x);  // AND 0 then OR x; carry ends at 0
        run_op(4'd4, 16'h0000);
        run_op(4'd5, x);
    endtask

    task automatic strobe(input logic t, input logic c);
        @(negedge clk); tick_i = t; eclr_i = c;
        @(negedge clk); tick_i = 1'b0; eclr_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R12 reset", 16'h0000, fl(0, 0, 0, 0));
    endtask

    task automatic t_add();
        set_acc(16'h7FFF);
        run_op(4'd0, 16'h0001);
        check("R4 R2 ADD 7FFF+1", 16'h8000, fl(1, 0, 0, 0));
        run_op(4'd0, 16'h8000);
        check("R4 R3 ADD carry out", 16'h0000, fl(0, 1, 1, 0));
        run_op(4'd1, 16'h0005);
        check("R4 ADC with carry in", 16'h0006, fl(0, 0, 0, 0));
        set_acc(16'hFFFF);
        run_op(4'd1, 16'h0001);
        check("R4 ADC wrap", 16'h0000, fl(0, 1, 1, 0));
        run_op(4'd1, 16'hFFFF);
        check("R4 ADC FFFF plus carry", 16'h0000, fl(0, 1, 1, 0));
    endtask

    task automatic t_sub();
        set_acc(16'h0005);
        run_op(4'd2, 16'h0007);
        check("R5 SUB borrow", 16'hFFFE, fl(1, 0, 1, 0));
        run_op(4'd3, 16'hFFFE);
        check("R5 SBC borrow in and out", 16'hFFFF, fl(1, 0, 1, 0));
        run_op(4'd3, 16'h0000);
        check("R5 SBC borrow in only", 16'hFFFE, fl(1, 0, 0, 0));
    endtask

    task automatic t_cp();
        set_acc(16'h1234);
        run_op(4'd9, 16'h1234);
        check("R8 CP equal", 16'h1234, fl(0, 1, 0, 0));
        run_op(4'd9, 16'h2000);
        check("R8 R5 CP borrow", 16'h1234, fl(1, 0, 1, 0));
    endtask

    task automatic t_logic();
        set_acc(16'h0000);
        run_op(4'd2, 16'h0001);  // FFFF with carry set
        run_op(4'd4, 16'h0F0F);
        check("R6 AND clears carry", 16'h0F0F, fl(0, 0, 0, 0));
        run_op(4'd9, 16'hFFFF);  // sets carry
        run_op(4'd5, 16'hF000);
        check("R6 OR", 16'hFF0F, fl(1, 0, 0, 0));
        run_op(4'd6, 16'hFF0F);
        check("R6 XOR to zero", 16'h0000, fl(0, 1, 0, 0));
        run_op(4'd10, 16'h1234);
        check("R6 CPL", 16'hFFFF, fl(1, 0, 0, 0));
    endtask

    task automatic t_incdec();
        set_acc(16'hFFFF);
        run_op(4'd7, 16'h0000);
        check("R7 INC wrap keeps C=0", 16'h0000, fl(0, 1, 0, 0));
        run_op(4'd9, 16'h0001);  // sets carry, acc stays 0
        run_op(4'd8, 16'h0000);
        check("R7 DEC keeps C=1", 16'hFFFF, fl(1, 0, 1, 0));
        run_op(4'd7, 16'h0000);
        check("R7 INC keeps C=1", 16'h0000, fl(0, 1, 1, 0));
    endtask

    task automatic t_neg();
        set_acc(16'h0001);
        run_op(4'd11, 16'h0000);
        check("R9 NEG 1", 16'hFFFF, fl(1, 0, 1, 0));
        set_acc(16'h0000);
        run_op(4'd11, 16'h0000);
        check("R9 NEG 0", 16'h0000, fl(0, 1, 0, 0));
        set_acc(16'h8000);
        run_op(4'd11, 16'h0000);
        check("R9 NEG 8000", 16'h8000, fl(1, 0, 1, 0));
    endtask

    task automatic t_nop();
        for (int k = 12; k < 16; k++) begin
            run_op(4'(k), 16'h1234);
            check("R10 unused code", 16'h8000, fl(1, 0, 1, 0));
        end
        @(negedge clk); exec_i = 1'b0; op_i = 4'd0; operand_i = 16'h1234;
        @(negedge clk);
        check("R10 exec low", 16'h8000, fl(1, 0, 1, 0));
    endtask

    task automatic t_event();
        strobe(1'b1, 1'b0);
        check("R11 tick sets E", 16'h8000, fl(1, 0, 1, 1));
        run_op(4'd0, 16'h0000);
        check("R11 op keeps E", 16'h8000, fl(1, 0, 0, 1));
        checks++;
        if ((flags_o & ~16'h8043) !== 16'h0000) begin
            failures++;
            $display("FAIL R1 unused flag bits=%h expected 0000", flags_o & ~16'h8043);
        end
        strobe(1'b0, 1'b1);
        check("R11 clear", 16'h8000, fl(1, 0, 0, 0));
        strobe(1'b1, 1'b1);
        check("R11 set wins", 16'h8000, fl(1, 0, 0, 1));
        do_reset();
        check("R12 reset clears all", 16'h0000, fl(0, 0, 0, 0));
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_cp();
        t_logic();
        t_incdec();
        t_neg();
        t_nop();
        t_event();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule